// File: doc/BRIEF.md
# Shared 64-bit Timer with Banked Comparators

The block holds one free-running 64-bit up-counter that several cores share, reached through a 32-bit register port. Each access carries a core number. That number selects a private bank for the issuing core, holding a 64-bit compare value, a 32-bit step value, an event flag and three mode bits. The counter itself, its run bit and its 8-bit clock divider are common to all cores.

The counter moves by one every (divider+1) clocks while it runs. For each core whose compare is armed, the block raises that core's event flag once the counter has reached the compare value. In stepping mode the compare value then moves forward by the step value, so the core receives a regular stream of events. Each core has one interrupt line, which is its event flag gated by its own interrupt mask bit.

Top module: `shared_tmr64`

## Requirements
- R1: After reset, the counter, every bank register, the run bit, the divider and all flags are 0, and every `irq` bit is 0.
- R2: While the run bit (control offset 0x08, bit 0) is 1 and the divider (control bits 15:8) holds D, the counter increases by 1 once every D+1 clocks. While the run bit is 0, the counter holds its value. The counter reads as its low word at offset 0x00 and its high word at offset 0x04.
- R3: A write to offset 0x00 or 0x04 loads that counter word only while the run bit is 0. While the run bit is 1, such a write has no effect on the counter.
- R4: The run bit and the divider are common to all cores. Control bits 1 (compare armed), 2 (interrupt mask open) and 3 (stepping), the compare value (0x10 low, 0x14 high), the step value (0x18) and the flag all belong to the bank that `core_id` selects. A write by one core leaves every other bank unchanged.
- R5: When a core's compare is armed and the counter is greater than or equal to that core's compare value at a clock edge, the core's flag (status offset 0x0C, bit 0) is 1 after that edge.
- R6: Writing 0x0C with bit 0 set clears the issuing core's flag. Writing 0x0C with bit 0 clear does not change the flag. A match at the same edge wins over the clear.
- R7: In stepping mode, at each edge where a match occurs, the core's compare value increases by its step value. A bus write to a compare word at that same edge replaces that word.
- R8: Bit i of `irq` is 1 exactly when core i's flag and its interrupt mask bit are both 1.
- R9: A read returns the selected register with the control layout {16'b0, divider, 4'b0, stepping, mask, armed, run}, the status as {31'b0, flag}, and 0 for any offset not listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_id | input | CW | Number of the core issuing the access |
| wr | input | 1 | Write strobe for one clock |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` in the bank `core_id` selects, combinational |
| irq | output | NCORE | One interrupt line per core |

## Verification
A write becomes visible on `rdata` in the cycle after the clock edge that captures it. A flag rises at the edge after the counter reaches the compare value, and the compare value steps at that same edge. The counter moves at the edge where the divider phase reaches D. `irq` follows the flag and the mask with no delay. The reference model updates at every rising edge from the inputs held across that edge. It is compared with `rdata` and `irq` in the middle of the low phase that follows, after the registers have settled and before the next stimulus is driven. This puts every result in the exact cycle where it is due.

// File: rtl/shared_tmr64.sv
module shared_tmr64 #(
  parameter int NCORE = 2,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     core_id,
  input  logic              wr,
  input  logic [4:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCORE-1:0]  irq
);
  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08, A_STS = 5'h0C,
                         A_MLO = 5'h10, A_MHI = 5'h14, A_INC = 5'h18;

  logic [63:0] cnt;
  logic [7:0]  presc, pcnt;
  logic        en;
  logic [NCORE-1:0] cmpen, ien, auto_inc, flag, match, wsel;
  logic [NCORE-1:0][63:0] cmp;
  logic [NCORE-1:0][31:0] inc;

  always_comb
    for (int i = 0; i < NCORE; i++) begin
      wsel[i]  = wr && (core_id == CW'(i));
      match[i] = cmpen[i] && (cnt >= cmp[i]);
    end

  assign irq = flag & ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pcnt <= '0;
    end else if (en) begin
      if (pcnt >= presc) begin
        pcnt <= '0;
        cnt  <= cnt + 64'd1;
      end else
        pcnt <= pcnt + 8'd1;
    end else begin
      pcnt <= '0;
      if (wr && addr == A_CLO) cnt[31:0]  <= wdata;
      if (wr && addr == A_CHI) cnt[63:32] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      presc <= '0;
      cmpen <= '0;
      ien <= '0;
      auto_inc <= '0;
      flag <= '0;
      cmp <= '0;
      inc <= '0;
    end else begin
      for (int i = 0; i < NCORE; i++) begin
        if (match[i]) begin
          flag[i] <= 1'b1;
          if (auto_inc[i]) cmp[i] <= cmp[i] + {32'd0, inc[i]};
        end
        if (wsel[i]) begin
          case (addr)
            A_CTL: begin
              en          <= wdata[0];
              presc       <= wdata[15:8];
              cmpen[i]    <= wdata[1];
              ien[i]      <= wdata[2];
              auto_inc[i] <= wdata[3];
            end
            A_STS: if (wdata[0] && !match[i]) flag[i] <= 1'b0;
            A_MLO: cmp[i][31:0]  <= wdata;
            A_MHI: cmp[i][63:32] <= wdata;
            A_INC: inc[i] <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  logic [63:0] s_cmp;
  logic [31:0] s_inc;
  logic [3:0]  s_bits;
  always_comb begin
    s_cmp = '0;
    s_inc = '0;
    s_bits = '0;
    for (int i = 0; i < NCORE; i++)
      if (core_id == CW'(i)) begin
        s_cmp  = cmp[i];
        s_inc  = inc[i];
        s_bits = {auto_inc[i], ien[i], cmpen[i], flag[i]};
      end
  end

  always_comb
    case (addr)
      A_CLO:   rdata = cnt[31:0];
      A_CHI:   rdata = cnt[63:32];
      A_CTL:   rdata = {16'd0, presc, 4'd0, s_bits[3:1], en};
      A_STS:   rdata = {31'd0, s_bits[0]};
      A_MLO:   rdata = s_cmp[31:0];
      A_MHI:   rdata = s_cmp[63:32];
      A_INC:   rdata = s_inc;
      default: rdata = '0;
    endcase
endmodule

// File: rtl/shared_tmr64_chk.sv
module shared_tmr64_chk #(
  parameter int NCORE = 2,
  localparam int CW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input logic clk,
  input logic rst_n,
  input logic wr,
  input logic [4:0] addr,
  input logic wbit0,
  input logic [CW-1:0] core_id,
  input logic [NCORE-1:0] irq,
  input logic [63:0] cnt,
  input logic en,
  input logic [NCORE-1:0] cmpen,
  input logic [NCORE-1:0] ien,
  input logic [NCORE-1:0] auto_inc,
  input logic [NCORE-1:0] flag,
  input logic [NCORE-1:0][63:0] cmp,
  input logic [NCORE-1:0][31:0] inc
);
  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && !$past(wr)) |-> $stable(cnt));
  // R3
  no_load_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 64'd1));

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmpen[i]) && ($past(cnt) >= $past(cmp[i]))) |-> flag[i]);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr && core_id == CW'(i) && addr == 5'h0C && wbit0)
       && !$past(cmpen[i] && cnt >= cmp[i])) |-> !flag[i]);
    // R7
    auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmpen[i] && auto_inc[i] && cnt >= cmp[i])
       && !$past(wr && core_id == CW'(i) && (addr == 5'h10 || addr == 5'h14)))
      |-> cmp[i] == $past(cmp[i]) + {32'd0, $past(inc[i])});
    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ien[i] |-> !irq[i]);
  end
endmodule

bind shared_tmr64 shared_tmr64_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wbit0(wdata[0]),
  .core_id(core_id), .irq(irq), .cnt(cnt), .en(en), .cmpen(cmpen),
  .ien(ien), .auto_inc(auto_inc), .flag(flag), .cmp(cmp), .inc(inc));

// File: tb/shared_tmr64_bench.sv
`timescale 1ns/1ps
module shared_tmr64_bench;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [0:0] core_id = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0] irq;
  int total = 0, bad = 0, cycles = 0;
  bit started = 0;

  shared_tmr64 #(.NCORE(2)) u_shared_tmr64 (.clk(clk), .rst_n(rst_n), .core_id(core_id),
    .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  longint unsigned m_cnt, m_cmp[2];
  int unsigned m_inc[2];
  bit [7:0] m_pc, m_presc;
  bit m_en;
  bit m_flag[2], m_cmpen[2], m_ien[2], m_auto[2], mt[2];

  always @(posedge clk) begin
    started <= 1;
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_pc = 0; m_presc = 0; m_en = 0;
      for (int i = 0; i < 2; i++) begin
        m_cmp[i] = 0; m_inc[i] = 0; m_flag[i] = 0; m_cmpen[i] = 0; m_ien[i] = 0; m_auto[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) mt[i] = m_cmpen[i] && (m_cnt >= m_cmp[i]);
      if (m_en) begin
        if (m_pc >= m_presc) begin m_pc = 0; m_cnt++; end else m_pc++;
      end else begin
        m_pc = 0;
        if (wr && addr == 5'h00) m_cnt = {m_cnt[63:32], wdata};
        if (wr && addr == 5'h04) m_cnt = {wdata, m_cnt[31:0]};
      end
      for (int i = 0; i < 2; i++) begin
        if (mt[i]) begin
          m_flag[i] = 1;
          if (m_auto[i]) m_cmp[i] = m_cmp[i] + longint'(m_inc[i]);
        end
        if (wr && core_id == i) begin
          case (addr)
            5'h08: begin
              m_en = wdata[0]; m_presc = wdata[15:8];
              m_cmpen[i] = wdata[1]; m_ien[i] = wdata[2]; m_auto[i] = wdata[3];
            end
            5'h0C: if (wdata[0] && !mt[i]) m_flag[i] = 0;
            5'h10: m_cmp[i] = {m_cmp[i][63:32], wdata};
            5'h14: m_cmp[i] = {wdata, m_cmp[i][31:0]};
            5'h18: m_inc[i] = wdata;
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(int c, logic [4:0] a);
    case (a)
      5'h00: return m_cnt[31:0];
      5'h04: return m_cnt[63:32];
      5'h08: return {16'd0, m_presc, 4'd0, m_auto[c], m_ien[c], m_cmpen[c], m_en};
      5'h0C: return {31'd0, m_flag[c]};
      5'h10: return m_cmp[c][31:0];
      5'h14: return m_cmp[c][63:32];
      5'h18: return m_inc[c];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] a);
    case (a)
      5'h00, 5'h04: return "R2";
      5'h08: return "R4";
      5'h0C: return "R5";
      5'h10, 5'h14: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (started && rst_n) begin
      logic [1:0] ei;
      ei = {m_flag[1] & m_ien[1], m_flag[0] & m_ien[0]};
      chk(irq === ei, "R8", irq, ei);
      chk(rdata === exp_rd(core_id, addr), tag_of(addr), rdata, exp_rd(core_id, addr));
    end
  end

  task automatic wreg(input int c, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1; core_id = c[0:0]; addr = a; wdata = d;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic peek(input int c, input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    core_id = c[0:0]; addr = a;
    #1 v = rdata;
  endtask

  task automatic idle(input int n, input int c, input logic [4:0] a);
    @(negedge clk);
    core_id = c[0:0]; addr = a;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    peek(0, 5'h00, v); chk(v == 0, "R1", v, 0);
    peek(1, 5'h08, v); chk(v == 0, "R1", v, 0);
    chk(irq == 0, "R1", irq, 0);
    peek(0, 5'h1C, v); chk(v == 0, "R9", v, 0);

    wreg(0, 5'h10, 32'd20);
    wreg(0, 5'h08, 32'h0000_0007);
    idle(30, 0, 5'h0C);
    peek(0, 5'h0C, v); chk(v == 1, "R5", v, 1);
    chk(irq[0] == 1'b1, "R8", irq[0], 1);

    wreg(1, 5'h10, 32'd40);
    wreg(1, 5'h18, 32'd10);
    wreg(1, 5'h08, 32'h0000_020F);
    peek(0, 5'h10, v); chk(v == 20, "R4", v, 20);
    peek(0, 5'h08, v); chk(v == 32'h207, "R4", v, 32'h207);
    idle(150, 1, 5'h10);
    peek(1, 5'h10, v); chk(v > 40, "R7", v, 40);

    wreg(0, 5'h08, 32'h0000_0201);
    wreg(0, 5'h0C, 32'd1);
    peek(0, 5'h0C, v); chk(v == 0, "R6", v, 0);
    chk(irq[0] == 1'b0, "R8", irq[0], 0);
    wreg(1, 5'h0C, 32'd0);
    idle(40, 1, 5'h0C);
    peek(1, 5'h0C, v); chk(v == 1, "R6", v, 1);

    wreg(0, 5'h00, 32'hDEAD_0000);
    peek(0, 5'h00, v); chk(v < 32'h1000, "R3", v, 0);

    wreg(1, 5'h08, 32'h0000_0000);
    wreg(0, 5'h04, 32'd1);
    wreg(0, 5'h00, 32'd5);
    idle(5, 0, 5'h04);
    peek(0, 5'h04, v); chk(v == 1, "R3", v, 1);
    peek(0, 5'h00, v); chk(v == 5, "R2", v, 5);

    wreg(1, 5'h14, 32'd1);
    wreg(1, 5'h10, 32'd30);
    wreg(1, 5'h18, 32'd4);
    wreg(1, 5'h08, 32'h0000_030F);
    idle(200, 1, 5'h00);
    wreg(0, 5'h08, 32'h0000_0003);
    idle(60, 0, 5'h14);
    wreg(1, 5'h0C, 32'd1);
    idle(20, 1, 5'h10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule